// File: doc/BRIEF.md
# Byte-Addressed SPI Register Slave

This block lets an external host reach a bank of 16-bit registers over a four-wire serial link. The link runs with an idle-high clock. The slave captures the input line on rising clock edges and moves its output line on falling clock edges. Every transfer is one 16-bit word, sent most significant bit first. The top bit of a word selects write or read, the next seven bits give a byte address, and the low eight bits carry write data. Each register covers two byte addresses, so a write changes only one byte of it.

Reads are pipelined. A read command names either byte of a register. The whole register is then returned during the next transfer, while that transfer carries the host's next command. The bank holds four kinds of register:
- sample words from a datapath, each carrying an unread flag and an alarm flag;
- plain control words;
- a diagnostic flag word that clears when read;
- a command word whose bits stay raised until the function they start reports completion.

The serial pins are brought into the system clock domain through synchronizers, and all decoding runs on the system clock.

Top module: `spi_rb_slave`

## Requirements
- R1: A transfer is 16 bits, MSB first, taken from `mosi` on rising `sclk` while `cs_n` is low. Bit 15 = 1 means write, bits 14:8 are the byte address, and bits 7:0 are the write data.
- R2: The address map, in byte addresses: sample word i (i from 0) is at 0x02+2i, control word j is at 0x10+2j, the diagnostic word is at 0x3C and the command word is at 0x3E. An even address selects the low byte and an odd address the high byte. A write changes only the selected byte of a control word.
- R3: A read of either byte address returns the full 16-bit word on `miso` during the next transfer. A transfer that follows a write returns 0x0000.
- R4: Bit 15 of the returned word is on `miso` once `cs_n` falls. Each later bit appears after an `sclk` falling edge, starting with the second falling edge of the transfer. `miso_oe` is low whenever `cs_n` is high.
- R5: A write takes effect after the 16th rising `sclk` edge. A transfer ended by `cs_n` rising before 16 bits have no effect.
- R6: Writing a 1 to bit k of the command word's low byte raises `cmd_go[k]`. The bit stays high until `cmd_done[k]` pulses. Writing a 0 leaves it unchanged.
- R7: A sample word reads as {unread, alarm, value[13:0]}. A pulse on `out_load[i]` loads the value and sets the unread bit. Accepting a read of that word clears the unread bit. A load in the same cycle as the read wins.
- R8: The alarm bit (bit 14) of a sample word is 1 when any diagnostic flag is 1 at the time the read is accepted.
- R9: Diagnostic word bit 0 follows `supply_lo` and bit 1 follows `supply_hi`, and a read does not clear them. Bits 2 and up latch pulses of `diag_evt` and are cleared by accepting a read of the diagnostic word. An event in the same cycle as that read stays latched.
- R10: Writes to sample words, to the diagnostic word or to unused addresses change nothing. Reads of unused addresses return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle high |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Drive enable for `miso` |
| out_load | input | OUT_N | Per-word sample load strobe |
| out_val | input | OUT_N*14 | Sample values, word i in bits 14i+13:14i |
| diag_evt | input | DIAG_W-2 | Event pulses for the latched diagnostic flags |
| supply_lo | input | 1 | Supply-below-range level |
| supply_hi | input | 1 | Supply-above-range level |
| cmd_done | input | CMD_W | Completion pulses for command bits |
| ctrl_q | output | CTRL_N*16 | Control word contents, word j in bits 16j+15:16j |
| cmd_go | output | CMD_W | Pending command bits |

## Verification
A chain of back-to-back transfers mixes low-byte and high-byte writes with reads through even and odd addresses. Each returned word therefore shows whether the byte merge kept the untouched half and whether the one-transfer read delay is right. Reads of unused addresses, writes to read-only words and a write followed at once by a read separate a correct decoder from one that aliases or leaks stale data. Directed sequences then:
- load a sample and read it twice, which shows the unread flag clearing;
- raise an event and a supply level, which shows the alarm bit and which diagnostic flags survive a read;
- cut a write short, which shows it has no effect;
- set and complete command bits one at a time.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
   localparam int FRAME_W = 16;
   localparam int BYTE_W  = 8;
   localparam int ADDR_W  = 7;
   localparam int WORD_AW = ADDR_W - 1;
   localparam int VAL_W   = FRAME_W - 2;
   localparam int CNT_W   = $clog2(FRAME_W) + 1;

   typedef struct packed {
      logic              wr;
      logic [ADDR_W-1:0] addr;
      logic [BYTE_W-1:0] data;
   } frame_t;

   function automatic logic [FRAME_W-1:0] merge_byte(input logic [FRAME_W-1:0] old_w,
                                                      input logic hi_sel,
                                                      input logic [BYTE_W-1:0] b);
      logic [FRAME_W-1:0] r;
      r = old_w;
      if (hi_sel) r[FRAME_W-1:BYTE_W] = b;
      else        r[BYTE_W-1:0]       = b;
      return r;
   endfunction
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter
   import spi_rb_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_high,
   input  logic               cs_fall,
   input  logic               sclk_rise,
   input  logic               sclk_fall,
   input  logic               din,
   input  logic [FRAME_W-1:0] ld_word,
   output logic               frame_done,
   output frame_t             frame,
   output logic               dout
);
   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] sin, sout;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         sin        <= '0;
         sout       <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (cs_high) begin
            cnt <= '0;
         end else if (cs_fall) begin
            cnt  <= '0;
            sout <= ld_word;
         end else if (sclk_rise && cnt < CNT_W'(FRAME_W)) begin
            sin <= {sin[FRAME_W-2:0], din};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(FRAME_W - 1)) frame_done <= 1'b1;
         end else if (sclk_fall && cnt != '0 && cnt < CNT_W'(FRAME_W)) begin
            sout <= {sout[FRAME_W-2:0], 1'b0};
         end
      end
   end

   assign frame = frame_t'(sin);
   assign dout  = sout[FRAME_W-1];
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile
   import spi_rb_pkg::*;
#(
   parameter int OUT_N      = 4,
   parameter int CTRL_N     = 4,
   parameter int CTRL_WBASE = 8,
   parameter int DIAG_WORD  = 30,
   parameter int CMD_WORD   = 31,
   parameter int CMD_W      = 8,
   parameter int DIAG_W     = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_done,
   input  frame_t                  frame,
   input  logic [OUT_N-1:0]        out_load,
   input  logic [OUT_N*VAL_W-1:0]  out_val,
   input  logic [DIAG_W-3:0]       diag_evt,
   input  logic                    supply_lo,
   input  logic                    supply_hi,
   input  logic [CMD_W-1:0]        cmd_done,
   output logic [FRAME_W-1:0]      rd_word,
   output logic [CTRL_N*FRAME_W-1:0] ctrl_q,
   output logic [CMD_W-1:0]        cmd_go
);
   localparam int EVT_W = DIAG_W - 2;

   logic [WORD_AW-1:0] word;
   logic               rd_acc, wr_acc, hi_sel;
   logic [VAL_W-1:0]   oval  [OUT_N];
   logic [OUT_N-1:0]   ond;
   logic [FRAME_W-1:0] ctrl_r [CTRL_N];
   logic [EVT_W-1:0]   sticky;
   logic [1:0]         supply;
   logic               alarm;
   logic [FRAME_W-1:0] rd_val;

   assign word   = frame.addr[ADDR_W-1:1];
   assign hi_sel = frame.addr[0];
   assign rd_acc = frame_done && !frame.wr;
   assign wr_acc = frame_done &&  frame.wr;
   assign alarm  = |{sticky, supply};

   for (genvar i = 0; i < OUT_N; i++) begin : g_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            oval[i] <= '0;
            ond[i]  <= 1'b0;
         end else if (out_load[i]) begin
            oval[i] <= out_val[i*VAL_W +: VAL_W];
            ond[i]  <= 1'b1;
         end else if (rd_acc && int'(word) == i + 1) begin
            ond[i]  <= 1'b0;
         end
      end
   end

   for (genvar j = 0; j < CTRL_N; j++) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ctrl_r[j] <= '0;
         else if (wr_acc && int'(word) == CTRL_WBASE + j)
            ctrl_r[j] <= merge_byte(ctrl_r[j], hi_sel, frame.data);
      end
      assign ctrl_q[j*FRAME_W +: FRAME_W] = ctrl_r[j];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky <= '0;
         supply <= '0;
      end else begin
         supply <= {supply_hi, supply_lo};
         if (rd_acc && int'(word) == DIAG_WORD) sticky <= diag_evt;
         else                                   sticky <= sticky | diag_evt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_go <= '0;
      else if (wr_acc && int'(word) == CMD_WORD && !hi_sel)
         cmd_go <= (cmd_go & ~cmd_done) | frame.data[CMD_W-1:0];
      else
         cmd_go <= cmd_go & ~cmd_done;
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < OUT_N; i++)
         if (int'(word) == i + 1) rd_val = {ond[i], alarm, oval[i]};
      for (int j = 0; j < CTRL_N; j++)
         if (int'(word) == CTRL_WBASE + j) rd_val = ctrl_r[j];
      if (int'(word) == DIAG_WORD) rd_val = {{(FRAME_W-DIAG_W){1'b0}}, sticky, supply};
      if (int'(word) == CMD_WORD)  rd_val = {{(FRAME_W-CMD_W){1'b0}}, cmd_go};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_word <= '0;
      else if (frame_done) rd_word <= frame.wr ? '0 : rd_val;
   end
endmodule

// File: rtl/spi_rb_slave.sv
module spi_rb_slave
   import spi_rb_pkg::*;
#(
   parameter int OUT_N       = 4,
   parameter int CTRL_N      = 4,
   parameter int CTRL_WBASE  = 8,
   parameter int DIAG_WORD   = 30,
   parameter int CMD_WORD    = 31,
   parameter int CMD_W       = 8,
   parameter int DIAG_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sclk,
   input  logic                      cs_n,
   input  logic                      mosi,
   output logic                      miso,
   output logic                      miso_oe,
   input  logic [OUT_N-1:0]          out_load,
   input  logic [OUT_N*14-1:0]       out_val,
   input  logic [DIAG_W-3:0]         diag_evt,
   input  logic                      supply_lo,
   input  logic                      supply_hi,
   input  logic [CMD_W-1:0]          cmd_done,
   output logic [CTRL_N*16-1:0]      ctrl_q,
   output logic [CMD_W-1:0]          cmd_go
);
   localparam int WORDS = 1 << WORD_AW;

   if (OUT_N < 1 || OUT_N + 1 > CTRL_WBASE)
      $error("sample words overlap control words");
   if (CTRL_N < 1 || CTRL_WBASE + CTRL_N > DIAG_WORD)
      $error("control words overlap diagnostic word");
   if (DIAG_WORD == CMD_WORD || CMD_WORD >= WORDS || DIAG_WORD >= WORDS)
      $error("bad diagnostic or command word index");
   if (CMD_W < 1 || CMD_W > BYTE_W)
      $error("command width must fit one byte");
   if (DIAG_W < 3 || DIAG_W >= FRAME_W)
      $error("diagnostic width out of range");
   if (SYNC_STAGES < 2)
      $error("at least two synchronizer stages required");

   logic [2:0]         pin_s;
   logic               sclk_d, cs_d;
   logic               sclk_rise, sclk_fall, cs_fall, cs_high;
   logic               frame_done;
   frame_t             frame;
   logic [FRAME_W-1:0] rd_word;

   spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({sclk, cs_n, mosi}),
      .q    (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b1;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= pin_s[2];
         cs_d   <= pin_s[1];
      end
   end

   assign sclk_rise =  pin_s[2] & ~sclk_d;
   assign sclk_fall = ~pin_s[2] &  sclk_d;
   assign cs_fall   = ~pin_s[1] &  cs_d;
   assign cs_high   =  pin_s[1];

   spi_rb_shifter u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_high   (cs_high),
      .cs_fall   (cs_fall),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .din       (pin_s[0]),
      .ld_word   (rd_word),
      .frame_done(frame_done),
      .frame     (frame),
      .dout      (miso)
   );

   spi_rb_regfile #(
      .OUT_N(OUT_N), .CTRL_N(CTRL_N), .CTRL_WBASE(CTRL_WBASE),
      .DIAG_WORD(DIAG_WORD), .CMD_WORD(CMD_WORD), .CMD_W(CMD_W), .DIAG_W(DIAG_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_done(frame_done),
      .frame     (frame),
      .out_load  (out_load),
      .out_val   (out_val),
      .diag_evt  (diag_evt),
      .supply_lo (supply_lo),
      .supply_hi (supply_hi),
      .cmd_done  (cmd_done),
      .rd_word   (rd_word),
      .ctrl_q    (ctrl_q),
      .cmd_go    (cmd_go)
   );

   assign miso_oe = ~cs_n;
endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker #(
   parameter int CTRL_N = 4,
   parameter int CMD_W  = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  miso,
   input logic                  sclk_rise,
   input logic                  sclk_fall,
   input logic                  cs_fall,
   input logic                  frame_done,
   input logic [CTRL_N*16-1:0]  ctrl_q,
   input logic [CMD_W-1:0]      cmd_go,
   input logic [CMD_W-1:0]      cmd_done
);
   // R4: output bit moves only after a select fall or a clock fall
   p_dout_moves_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(sclk_fall || cs_fall) |=> $stable(miso));

   // R5: control words change only when a whole transfer completes
   p_ctrl_needs_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> $stable(ctrl_q));

   // R1: completion comes right after a sampled rising edge
   p_frame_after_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(sclk_rise));

   for (genvar k = 0; k < CMD_W; k++) begin : g_cmd
      // R6: a command bit rises only from a completed write
      p_cmd_rise_from_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(cmd_go[k]) |-> $past(frame_done));
      // R6: completion drops a pending bit
      p_cmd_clear_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_go[k] && cmd_done[k] && !frame_done) |=> !cmd_go[k]);
   end
endmodule

bind spi_rb_slave spi_rb_checker #(.CTRL_N(CTRL_N), .CMD_W(CMD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .miso      (miso),
   .sclk_rise (sclk_rise),
   .sclk_fall (sclk_fall),
   .cs_fall   (cs_fall),
   .frame_done(frame_done),
   .ctrl_q    (ctrl_q),
   .cmd_go    (cmd_go),
   .cmd_done  (cmd_done)
);

// File: tb/spi_rb_slave_tb.sv
module spi_rb_slave_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int OUT_N      = 4;
   localparam int CTRL_N     = 4;
   localparam int CMD_W      = 8;
   localparam int DIAG_W     = 8;
   localparam int NVEC       = 15;

   // {command, expected word returned during that transfer}
   localparam logic [31:0] VEC [NVEC] = '{
      32'h9012_0000, 32'h9134_0000, 32'h1000_0000, 32'h1100_3412,
      32'h92AB_3412, 32'h9056_0000, 32'h1000_0000, 32'h1200_3456,
      32'h3000_00AB, 32'h3A00_0000, 32'h8255_0000, 32'h1000_0000,
      32'h0000_3456, 32'h0200_0000, 32'h0000_0000
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
   logic miso, miso_oe;
   logic [OUT_N-1:0]      out_load = '0;
   logic [OUT_N*14-1:0]   out_val  = '0;
   logic [DIAG_W-3:0]     diag_evt = '0;
   logic                  supply_lo = 1'b0, supply_hi = 1'b0;
   logic [CMD_W-1:0]      cmd_done = '0;
   logic [CTRL_N*16-1:0]  ctrl_q;
   logic [CMD_W-1:0]      cmd_go;

   int nchk = 0, nerr = 0;
   bit done = 1'b0;
   logic [15:0] rx;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_rb_slave dut_i (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .miso(miso), .miso_oe(miso_oe), .out_load(out_load), .out_val(out_val),
      .diag_evt(diag_evt), .supply_lo(supply_lo), .supply_hi(supply_hi),
      .cmd_done(cmd_done), .ctrl_q(ctrl_q), .cmd_go(cmd_go)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] r);
      r = '0;
      cs_n = 1'b0;
      idle(HALF);
      for (int b = 15; b > 15 - nbits; b--) begin
         sclk = 1'b0;
         mosi = tx[b];
         idle(HALF);
         r[b] = miso;
         if (b == 8) chk("R4 oe in frame", 64'(miso_oe), 64'd1);
         sclk = 1'b1;
         idle(HALF);
      end
      cs_n = 1'b1;
      idle(2 * HALF);
   endtask

   task automatic pulse_load(input int i, input logic [13:0] v);
      out_val[i*14 +: 14] = v;
      out_load[i] = 1'b1;
      idle(1);
      out_load[i] = 1'b0;
      idle(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
         $finish;
      end
   end

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(5);
      // reset state
      chk("R4 reset oe", 64'(miso_oe), 64'd0);
      chk("R2 reset ctrl", 64'(ctrl_q), 64'd0);
      chk("R6 reset cmd", 64'(cmd_go), 64'd0);

      // R1 R2 R3 R10: pipelined command chain
      for (int v = 0; v < NVEC; v++) begin
         xfer(VEC[v][31:16], 16, rx);
         chk($sformatf("R3 vector %0d", v), 64'(rx), 64'(VEC[v][15:0]));
      end
      chk("R2 byte merge", 64'(ctrl_q), {32'h0, 16'h00AB, 16'h3456});
      chk("R4 oe idle", 64'(miso_oe), 64'd0);

      // R5: cut-short write has no effect
      xfer(16'h9077, 12, rx);
      chk("R5 aborted write", 64'(ctrl_q[15:0]), 64'h3456);
      xfer(16'h9177, 16, rx);
      chk("R5 full write", 64'(ctrl_q[15:0]), 64'h7756);

      // R7: unread flag
      pulse_load(0, 14'h1234);
      xfer(16'h0200, 16, rx);
      xfer(16'h0300, 16, rx);
      chk("R7 unread set", 64'(rx), 64'h9234);
      xfer(16'h0000, 16, rx);
      chk("R7 unread cleared", 64'(rx), 64'h1234);

      // R8 R9: alarm and diagnostic flags
      diag_evt[0] = 1'b1; idle(1); diag_evt[0] = 1'b0;
      supply_lo = 1'b1;
      idle(4);
      xfer(16'h0200, 16, rx);
      xfer(16'h3C00, 16, rx);
      chk("R8 alarm bit", 64'(rx), 64'h5234);
      xfer(16'h3C00, 16, rx);
      chk("R9 flags before read", 64'(rx), 64'h0005);
      xfer(16'h0000, 16, rx);
      chk("R9 event cleared supply kept", 64'(rx), 64'h0001);
      supply_lo = 1'b0;
      idle(4);
      xfer(16'h3C00, 16, rx);
      xfer(16'h0000, 16, rx);
      chk("R9 supply self clear", 64'(rx), 64'h0000);

      // R10: write to diagnostic word ignored
      xfer(16'hBCFF, 16, rx);
      xfer(16'h3C00, 16, rx);
      xfer(16'h0000, 16, rx);
      chk("R10 diag write ignored", 64'(rx), 64'h0000);

      // R6: command bits
      xfer(16'hBE05, 16, rx);
      chk("R6 cmd set", 64'(cmd_go), 64'h05);
      cmd_done[0] = 1'b1; idle(1); cmd_done[0] = 1'b0; idle(2);
      chk("R6 cmd done bit0", 64'(cmd_go), 64'h04);
      xfer(16'hBE00, 16, rx);
      chk("R6 write zero no effect", 64'(cmd_go), 64'h04);
      xfer(16'hBF01, 16, rx);
      chk("R6 high byte ignored", 64'(cmd_go), 64'h04);
      cmd_done[2] = 1'b1; idle(1); cmd_done[2] = 1'b0; idle(2);
      chk("R6 cmd done bit2", 64'(cmd_go), 64'h00);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end
endmodule